// File: doc/BRIEF.md
# Multi-Format Mini-Float to Binary32 Widener

This block turns a packed small floating-point number into an IEEE 754 binary32 word. A 3-bit selector chooses the layout of the input on each transfer. There are four 8-bit layouts, taken from the low byte of the 16-bit input word, and two 16-bit layouts. The 8-bit layouts differ in several ways: whether a sign is present, the exponent width, the mantissa width and the bias. One of them has a bias of 8 and one has no sign at all.

Every supported input value can be represented exactly in binary32, so no rounding takes place. Zeros keep their sign. Subnormal inputs are normalised into ordinary binary32 numbers with a leading-zero count. The all-ones exponent is a special value in the two 16-bit layouts only; the 8-bit layouts treat it as a finite value.

The result is registered. It appears with a valid flag one clock after the input strobe. A selector value that names no layout gives zero and raises an error flag.

Top module: `mf2sp_convert`

## Requirements
- R1: While reset is high and in the cycle after it, `out_valid`, `out_err` and `out_word` are all 0.
- R2: `out_valid` equals `in_valid` from the previous cycle. When `in_valid` is low, `out_word` and `out_err` keep their previous values.
- R3: Selector 0 reads the byte as sign bit 7, exponent bits 6:4 and mantissa bits 3:0, with bias 7. A normal input gives binary32 exponent e-7+127, and the mantissa fills the top of the 23-bit fraction.
- R4: Selector 1 uses the same bit split as selector 0 but bias 8, so the binary32 exponent is e-8+127.
- R5: Selector 2 reads sign bit 7, exponent bits 6:3 and mantissa bits 2:0, with bias 7.
- R6: Selector 3 has no sign. It reads exponent bits 7:4 and mantissa bits 3:0 with bias 7, and its result always has sign bit 0.
- R7: Selector 4 reads a 16-bit word as sign bit 15, exponent bits 14:10 and mantissa bits 9:0, with bias 15.
- R8: Selector 5 reads sign bit 15, exponent bits 14:7 and mantissa bits 6:0, with bias 127. Its result is the input word placed in the upper half of binary32, with the lower 16 bits zero. Subnormal inputs therefore stay binary32 subnormals.
- R9: An exponent of 0 with a mantissa of 0 gives a zero of the input's sign (0x00000000 or 0x80000000).
- R10: An exponent of 0 with a nonzero mantissa is a subnormal of value m·2^(1-bias-MW), where MW is the mantissa width. For selectors 0 to 4 it is normalised into a binary32 normal number with exponent 127-bias-lz, where lz counts the leading zeros of the mantissa field.
- R11: For selectors 4 and 5, an all-ones exponent gives an infinity (exponent 0xFF, fraction 0) when the mantissa is 0. Otherwise it gives a quiet NaN: exponent 0xFF, fraction bit 22 set, and the mantissa kept below it.
- R12: For selectors 0 to 3, an all-ones exponent is an ordinary finite number and never produces exponent 0xFF.
- R13: Selectors 6 and 7 give `out_word` = 0 with `out_err` = 1. Every other selector gives `out_err` = 0.
- R14: For selectors 0 to 3, the input bits 15:8 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| in_fmt | input | 3 | Layout selector (0..5 valid) |
| in_word | input | 16 | Packed input value (8-bit layouts use bits 7:0) |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_word | output | 32 | binary32 result |
| out_err | output | 1 | Unsupported selector was given |

## Verification
Random words are spread across all eight selector values. This exercises the generic rebasing of the exponent and the placement of the mantissa, and it separates the layouts by their field boundaries and their biases. Directed words then cover the cases that random stimulus rarely reaches:
- zeros of both signs;
- single-bit subnormal mantissas, which test each leading-zero count;
- all-ones exponents, which must give infinity or NaN in the 16-bit layouts but stay finite in the 8-bit layouts;
- the smallest subnormal of the 1/8/7 layout, which must stay subnormal.

The same low byte is applied twice with different upper bytes, which shows that the upper byte is ignored. An idle cycle with a changed input word shows that the result is held.

// File: rtl/mf2sp_pkg.sv
package mf2sp_pkg;
  localparam int IN_W     = 16;
  localparam int OUT_W    = 32;
  localparam int FRAC_W   = 23;
  localparam int EXP_W    = 8;
  localparam int OUT_BIAS = 127;
  localparam int MAN_AL_W = 10;  // widest input mantissa
  localparam int SEL_W    = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_S3M4_B7 = 3'd0,
    SEL_S3M4_B8 = 3'd1,
    SEL_S4M3    = 3'd2,
    SEL_U4M4    = 3'd3,
    SEL_S5M10   = 3'd4,
    SEL_S8M7    = 3'd5,
    SEL_BAD6    = 3'd6,
    SEL_BAD7    = 3'd7
  } sel_e;

  typedef struct packed {
    logic                sgn;
    logic [EXP_W-1:0]    exp;
    logic [MAN_AL_W-1:0] man_al;    // mantissa left-aligned
    logic [EXP_W-1:0]    bias;
    logic                exp_ones;
    logic                has_special;
    logic                upper_half;  // 1/8/7 layout: direct placement
    logic                bad;
  } fields_t;
endpackage

// File: rtl/mf2sp_unpack.sv
module mf2sp_unpack
  import mf2sp_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic [IN_W-1:0]  word,
  output fields_t          fld
);
  always_comb begin
    fld = '0;
    unique case (sel_e'(sel))
      SEL_S3M4_B7, SEL_S3M4_B8: begin
        fld.sgn      = word[7];
        fld.exp      = {5'd0, word[6:4]};
        fld.man_al   = {word[3:0], 6'd0};
        fld.bias     = (sel_e'(sel) == SEL_S3M4_B8) ? 8'd8 : 8'd7;
        fld.exp_ones = &word[6:4];
      end
      SEL_S4M3: begin
        fld.sgn      = word[7];
        fld.exp      = {4'd0, word[6:3]};
        fld.man_al   = {word[2:0], 7'd0};
        fld.bias     = 8'd7;
        fld.exp_ones = &word[6:3];
      end
      SEL_U4M4: begin
        fld.sgn      = 1'b0;
        fld.exp      = {4'd0, word[7:4]};
        fld.man_al   = {word[3:0], 6'd0};
        fld.bias     = 8'd7;
        fld.exp_ones = &word[7:4];
      end
      SEL_S5M10: begin
        fld.sgn         = word[15];
        fld.exp         = {3'd0, word[14:10]};
        fld.man_al      = word[9:0];
        fld.bias        = 8'd15;
        fld.exp_ones    = &word[14:10];
        fld.has_special = 1'b1;
      end
      SEL_S8M7: begin
        fld.sgn         = word[15];
        fld.exp         = word[14:7];
        fld.man_al      = {word[6:0], 3'd0};
        fld.bias        = 8'd127;
        fld.exp_ones    = &word[14:7];
        fld.has_special = 1'b1;
        fld.upper_half  = 1'b1;
      end
      default: fld.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/mf2sp_lzc.sv
module mf2sp_lzc #(
  parameter int W  = 10,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/mf2sp_convert.sv
module mf2sp_convert
  import mf2sp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SEL_W-1:0]  in_fmt,
  input  logic [IN_W-1:0]   in_word,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_word,
  output logic              out_err
);
  localparam int LZ_W  = $clog2(MAN_AL_W + 1);
  localparam int EXT_W = EXP_W + 2;
  localparam int PAD_W = FRAC_W - MAN_AL_W;

  fields_t          fld;
  logic [LZ_W-1:0]  lz;
  logic [EXT_W-1:0] e_norm, e_sub;
  logic [MAN_AL_W-1:0] frac_sub;
  logic             exp_zero, man_zero;
  logic [OUT_W-1:0] res;

  mf2sp_unpack u_unpack (.sel(in_fmt), .word(in_word), .fld(fld));
  mf2sp_lzc #(.W(MAN_AL_W)) u_lzc (.vec(fld.man_al), .cnt(lz));

  always_comb begin
    exp_zero = (fld.exp == '0);
    man_zero = (fld.man_al == '0);
    e_norm   = EXT_W'(fld.exp) - EXT_W'(fld.bias) + EXT_W'(OUT_BIAS);
    e_sub    = EXT_W'(OUT_BIAS) - EXT_W'(fld.bias) - EXT_W'(lz);
    frac_sub = fld.man_al << (EXT_W'(lz) + EXT_W'(1));
    if (fld.bad)
      res = '0;
    else if (fld.upper_half)
      res = {in_word, 16'd0} | ((fld.exp_ones && !man_zero) ? 32'h0040_0000 : 32'd0);
    else if (exp_zero && man_zero)
      res = {fld.sgn, 31'd0};
    else if (exp_zero)
      res = {fld.sgn, e_sub[EXP_W-1:0], frac_sub, PAD_W'(0)};
    else if (fld.has_special && fld.exp_ones)
      res = man_zero ? {fld.sgn, 8'hFF, 23'd0}
                     : {fld.sgn, 8'hFF, 1'b1, fld.man_al[MAN_AL_W-2:0], PAD_W'(0)};
    else
      res = {fld.sgn, e_norm[EXP_W-1:0], fld.man_al, PAD_W'(0)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= res;
        out_err  <= fld.bad;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid && !rst));                                  // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> $stable(out_word) && $stable(out_err));            // R2
  AST_BAD_SEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(in_fmt) >= 3'd6 |-> out_err && out_word == '0);     // R13
  AST_GOOD_SEL_NOERR: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(in_fmt) < 3'd6 |-> !out_err);                        // R13
  AST_UNSIGNED_POS: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(in_fmt) == 3'd3 |-> !out_word[31]);                  // R6
  AST_SMALL_FINITE: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(in_fmt) < 3'd4 |-> out_word[30:23] != 8'hFF);       // R12
  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_word[30:23] == 8'hFF && out_word[22:0] != '0
    |-> out_word[22]);                                                      // R11
endmodule

// File: tb/mf2sp_convert_tb.sv
module mf2sp_convert_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  in_fmt;
  logic [15:0] in_word;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_err;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  mf2sp_convert u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt),
    .in_word(in_word), .out_valid(out_valid), .out_word(out_word),
    .out_err(out_err)
  );

  function automatic logic [31:0] ref_conv(input logic [2:0] f,
                                           input logic [15:0] w,
                                           output string tag);
    int ew, mw, bias, e, m, ex, sig;
    logic s, spec;
    logic [31:0] sig24, frac;
    spec = 1'b0; s = 1'b0; ew = 0; mw = 0; bias = 0;
    case (f)
      3'd0: begin ew = 3; mw = 4; bias = 7;  s = w[7]; tag = "R3"; end
      3'd1: begin ew = 3; mw = 4; bias = 8;  s = w[7]; tag = "R4"; end
      3'd2: begin ew = 4; mw = 3; bias = 7;  s = w[7]; tag = "R5"; end
      3'd3: begin ew = 4; mw = 4; bias = 7;  s = 1'b0; tag = "R6"; end
      3'd4: begin ew = 5; mw = 10; bias = 15; s = w[15]; spec = 1'b1; tag = "R7"; end
      3'd5: begin ew = 8; mw = 7; bias = 127; s = w[15]; spec = 1'b1; tag = "R8"; end
      default: begin tag = "R13"; return 32'd0; end
    endcase
    e = (int'(w) >> mw) & ((1 << ew) - 1);
    m = int'(w) & ((1 << mw) - 1);
    if (e == 0 && m == 0) begin tag = "R9"; return {s, 31'd0}; end
    if (spec && e == (1 << ew) - 1) begin
      tag = "R11";
      if (m == 0) return {s, 8'hFF, 23'd0};
      frac = 32'(m) << (23 - mw);
      return {s, 8'hFF, 1'b1, frac[21:0]};
    end
    if (!spec && e == (1 << ew) - 1) tag = "R12";
    if (e == 0) begin
      tag = "R10";
      ex = 1 - bias + 127;
      sig = m;
      while (sig < (1 << mw)) begin sig = sig << 1; ex = ex - 1; end
    end else begin
      ex = e - bias + 127;
      sig = m | (1 << mw);
    end
    sig24 = 32'(sig) << (23 - mw);
    if (ex <= 0) begin
      frac = sig24 >> (1 - ex);
      return {s, 8'd0, frac[22:0]};
    end
    return {s, ex[7:0], sig24[22:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] f, input logic [15:0] w);
    string tag;
    logic [31:0] exp;
    exp = ref_conv(f, w, tag);
    @(negedge clk);
    in_valid = 1'b1; in_fmt = f; in_word = w;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {out_valid, out_err, out_word[29:0]} ^ {2'b00, 30'd0} , {1'b1, (f > 3'd5), exp[29:0]});
    check(tag, {30'd0, out_word[31:30]}, {30'd0, exp[31:30]});
  endtask

  task automatic lit(input string tag, input logic [2:0] f, input logic [15:0] w,
                     input logic [31:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_fmt = f; in_word = w;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, out_word, exp);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 1'b0; in_fmt = 3'd0; in_word = 16'h0;
    repeat (3) @(negedge clk);
    check("R1", {29'd0, out_valid, out_err, |out_word}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {29'd0, out_valid, out_err, |out_word}, 32'd0);

    // directed literals
    lit("R3",  3'd0, 16'h0038, 32'h3DC0_0000);
    lit("R4",  3'd1, 16'h0040, 32'h3D80_0000);
    lit("R5",  3'd2, 16'h007F, 32'h43F0_0000);
    lit("R6",  3'd3, 16'h00FF, 32'h43F8_0000);
    lit("R7",  3'd4, 16'h3C00, 32'h3F80_0000);
    lit("R8",  3'd5, 16'h3F80, 32'h3F80_0000);
    lit("R8",  3'd5, 16'h0001, 32'h0001_0000);
    lit("R9",  3'd0, 16'h0080, 32'h8000_0000);
    lit("R9",  3'd4, 16'h0000, 32'h0000_0000);
    lit("R10", 3'd0, 16'h0001, 32'h3A80_0000);
    lit("R11", 3'd4, 16'h7C00, 32'h7F80_0000);
    lit("R11", 3'd4, 16'hFC01, 32'hFFC0_2000);
    lit("R11", 3'd5, 16'h7F81, 32'h7FC1_0000);
    lit("R12", 3'd0, 16'h007F, 32'h43F8_0000 - 32'h0400_0000);
    lit("R13", 3'd6, 16'h3C00, 32'h0000_0000);
    check("R13", {31'd0, out_err}, 32'd1);

    // subnormal sweep: every single-bit mantissa, every valid selector
    for (int f = 0; f < 6; f++)
      for (int b2 = 0; b2 < 10; b2++) apply(3'(f), 16'(1 << b2));
    // all-ones exponent patterns
    for (int f = 0; f < 8; f++) begin
      apply(3'(f), 16'h7FFF); apply(3'(f), 16'hFFFF); apply(3'(f), 16'h7F80);
    end

    // R14: upper byte ignored by 8-bit selectors
    for (int k = 0; k < 40; k++) begin
      logic [2:0] f;
      logic [7:0] lo;
      f = 3'($urandom_range(0, 3));
      lo = 8'($urandom);
      @(negedge clk); in_valid = 1'b1; in_fmt = f; in_word = {8'h00, lo};
      @(negedge clk); a = out_word;
      in_word = {8'($urandom) | 8'h01, lo};
      @(negedge clk); in_valid = 1'b0; b = out_word;
      check("R14", b, a);
    end

    // R2: hold on idle with changed inputs
    apply(3'd4, 16'h4000);
    a = out_word;
    in_fmt = 3'd7; in_word = 16'h1234;
    @(negedge clk);
    check("R2", {31'd0, out_valid}, 32'd0);
    check("R2", out_word, a);
    check("R2", {31'd0, out_err}, 32'd0);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      apply(3'($urandom_range(0, 7)), 16'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule